// File: doc/BRIEF.md
# MDIO Management Master

This block is the management-side master of a serial PHY management link. It uses a clause-22 frame format. Software programs a 16-bit command word that names a PHY, a register inside it, the transfer direction and a clock-range code. Setting the busy bit in that word while the block is idle starts a transfer. A separate 16-bit data register supplies the value for a write and receives the value from a read.

For each transfer the block derives the management clock MDC from its own clock. The divide ratio comes from the range code. The block then shifts a 64-bit frame onto the data line, MSB first, and changes the line only on falling MDC edges. On reads it releases the line for the turnaround and the data field, and it samples the PHY on rising MDC edges. When the frame ends, the busy bit clears on its own. Software polls busy before it issues the next command.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, busy reads 0, both registers read 0, MDC is low and the output enable is low.
- R2: The command word holds PHY address [15:11], register address [10:6], range code [5:2], write flag [1] (1 = write) and busy [0]. A command write with bit 0 = 1 while idle starts a transfer, and busy reads 1 from the next cycle.
- R3: Range codes 0 to 5 give an MDC period of 42, 62, 16, 26, 102 and 122 clocks. MDC is low for the first half of each period and high for the second half, and a transfer lasts exactly 64 periods.
- R4: Range codes 8 to 15 give MDC periods of 4, 6, 8, 10, 12, 14, 16 and 18 clocks.
- R5: The reserved codes 6 and 7 behave as code 0 (period 42).
- R6: A write frame is 32 ones, 01, opcode 01, the PHY address, the register address, turnaround 10, and then the 16 data bits, with each field MSB first. Every bit is driven for one full MDC period.
- R7: A read frame uses opcode 10. The output enable is low for frame bits 46 to 63, which are the turnaround and data. The data bits are sampled on the rising MDC edges of bits 48 to 63, MSB first, and the data register holds the result once busy reads 0.
- R8: MDC stays low while idle. During a transfer the data output changes only in the cycle in which MDC falls.
- R9: Command and data register writes are ignored while busy is set. This includes a command write that lands in the same cycle in which the transfer ends.
- R10: Busy clears by itself after the last frame bit. The command word then reads back with its other fields unchanged.
- R11: A command write with bit 0 = 0 stores the word but starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, source of MDC |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 = command word, 1 = data register |
| reg_wdata | input | 16 | Write value |
| cmd_rdata | output | 16 | Command word readback, bit 0 is live busy |
| data_rdata | output | 16 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The risky overlap is the end of a frame, where busy clears and read data is loaded, meeting a new command write from software in the same clock. The bench counts clocks from the start edge and places a command write with the busy bit set exactly on the edge where the transfer ends. It then checks that busy reads 0, that the command word is unchanged and that no second frame starts. Register writes in the middle of a transfer are also injected, and the bench checks that the captured frame and the data register are not disturbed.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int REG_W    = 16;
  localparam int ADDR_W   = 5;
  localparam int CODE_W   = 4;
  localparam int PRE_LEN  = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2*ADDR_W + 2 + REG_W;
  localparam int TA_IDX   = FRAME_LEN - REG_W - 2;
  localparam int DAT_IDX  = FRAME_LEN - REG_W;
  localparam int BIT_W    = $clog2(FRAME_LEN);
  localparam int DIV_W    = 7;

  // MDC period in clocks for a range code
  function automatic logic [DIV_W-1:0] period_of(input logic [CODE_W-1:0] code);
    logic [DIV_W-1:0] p;
    case (code)
      4'd0, 4'd6, 4'd7: p = 7'd42;
      4'd1:             p = 7'd62;
      4'd2:             p = 7'd16;
      4'd3:             p = 7'd26;
      4'd4:             p = 7'd102;
      4'd5:             p = 7'd122;
      default:          p = 7'd4 + {3'd0, code[2:0], 1'b0};
    endcase
    return p;
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              mdc,
  output logic              rise_p,
  output logic              fall_p
);
  logic [DIV_W-1:0] cnt_q, cnt_d, period, half;
  logic             mdc_q, mdc_d;

  assign period = period_of(code);
  assign half   = period >> 1;
  assign rise_p = run && (cnt_q == half - 7'd1);
  assign fall_p = run && (cnt_q == period - 7'd1);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (restart || !run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else begin
      cnt_d = fall_p ? '0 : cnt_q + 7'd1;
      if (rise_p)      mdc_d = 1'b1;
      else if (fall_p) mdc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q < period);
  p_fall_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && $past(run) && $fell(mdc_q)) |-> cnt_q == '0);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              is_wr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              active,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [REG_W-1:0]  rd_data
);
  logic [FRAME_LEN-1:0] sr_q, sr_d;
  logic [BIT_W-1:0]     bit_q, bit_d, bit_nx;
  logic                 act_q, act_d, oe_q, oe_d, wr_q, wr_d;
  logic [REG_W-1:0]     rd_q, rd_d;
  logic                 last_bit;

  assign last_bit = (bit_q == BIT_W'(FRAME_LEN - 1));
  assign bit_nx   = bit_q + 1'b1;
  assign done     = act_q && fall_p && last_bit;

  always_comb begin
    sr_d  = sr_q;
    bit_d = bit_q;
    act_d = act_q;
    oe_d  = oe_q;
    wr_d  = wr_q;
    rd_d  = rd_q;
    if (start) begin
      sr_d  = {{PRE_LEN{1'b1}}, 2'b01, (is_wr ? 2'b01 : 2'b10),
               phy_addr, reg_addr, 2'b10, wr_data};
      bit_d = '0;
      act_d = 1'b1;
      oe_d  = 1'b1;
      wr_d  = is_wr;
    end else if (act_q) begin
      if (rise_p && !wr_q && (bit_q >= BIT_W'(DAT_IDX)))
        rd_d = {rd_q[REG_W-2:0], mdio_i};
      if (fall_p) begin
        sr_d  = {sr_q[FRAME_LEN-2:0], 1'b0};
        bit_d = bit_nx;
        if (last_bit) begin
          act_d = 1'b0;
          oe_d  = 1'b0;
        end else begin
          oe_d  = wr_q || (bit_nx < BIT_W'(TA_IDX));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      bit_q <= '0;
      act_q <= 1'b0;
      oe_q  <= 1'b0;
      wr_q  <= 1'b0;
      rd_q  <= '0;
    end else begin
      sr_q  <= sr_d;
      bit_q <= bit_d;
      act_q <= act_d;
      oe_q  <= oe_d;
      wr_q  <= wr_d;
      rd_q  <= rd_d;
    end
  end

  assign active  = act_q;
  assign mdio_o  = sr_q[FRAME_LEN-1];
  assign mdio_oe = oe_q;
  assign rd_data = rd_q;

  p_mdio_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));
  p_oe_off_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !wr_q && (bit_q >= BIT_W'(TA_IDX))) |-> !mdio_oe);
  p_oe_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && wr_q) |-> mdio_oe);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] cmd_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [REG_W-1:0] cmd_q, cmd_d, data_q, data_d, rd_data;
  logic             busy, cmd_acc, dat_acc, start, active, done, rise_p, fall_p;

  assign busy    = cmd_q[0];
  assign cmd_acc = reg_wr && !reg_sel && !busy;
  assign dat_acc = reg_wr &&  reg_sel && !busy;
  assign start   = cmd_acc && reg_wdata[0];

  always_comb begin
    cmd_d  = cmd_q;
    data_d = data_q;
    if (cmd_acc) cmd_d = reg_wdata;
    if (dat_acc) data_d = reg_wdata;
    if (done) begin
      cmd_d[0] = 1'b0;
      if (!cmd_q[1]) data_d = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      data_q <= data_d;
    end
  end

  mdio_clk_div u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (active),
    .restart (start),
    .code    (cmd_q[5:2]),
    .mdc     (mdc),
    .rise_p  (rise_p),
    .fall_p  (fall_p)
  );

  mdio_frame_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .phy_addr (reg_wdata[15:11]),
    .reg_addr (reg_wdata[10:6]),
    .is_wr    (reg_wdata[1]),
    .wr_data  (data_q),
    .rise_p   (rise_p),
    .fall_p   (fall_p),
    .mdc      (mdc),
    .mdio_i   (mdio_i),
    .active   (active),
    .done     (done),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_data  (rd_data)
  );

  assign cmd_rdata  = cmd_q;
  assign data_rdata = data_q;

  p_mdc_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> (cmd_q[15:1] == $past(cmd_q[15:1])));
  p_busy_tracks_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy == active);
  p_release_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!mdio_oe && !mdc));
endmodule

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] cmd_rdata, data_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b0;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mdio_mgmt_master u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_rdata(cmd_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY responder and frame monitor
  int          falls = 0, base = 0;
  logic [63:0] cap, oecap;
  logic [15:0] rd_val = '0;

  always @(posedge mdc) begin
    int k;
    k = falls - base;
    if (k >= 0 && k < 64) begin
      cap[63-k]   = mdio_o;
      oecap[63-k] = mdio_oe;
    end
  end

  always @(negedge mdc) begin
    int nk;
    nk = falls + 1 - base;
    falls <= falls + 1;
    if (nk >= 48 && nk < 64) mdio_i <= rd_val[63-nk];
  end

  // line activity monitor
  int   hi_cnt = 0, viol = 0, idle_hi = 0;
  logic prev_mdo = 1'b0, prev_mdc = 1'b0, prev_busy = 1'b0;
  always @(negedge clk) begin
    if (cmd_rdata[0] && mdc) hi_cnt++;
    if (!cmd_rdata[0] && mdc) idle_hi++;
    if (cmd_rdata[0] && prev_busy && mdio_o != prev_mdo && !(prev_mdc && !mdc)) viol++;
    prev_mdo = mdio_o; prev_mdc = mdc; prev_busy = cmd_rdata[0];
  end

  function automatic int exp_period(input logic [3:0] c);
    case (c)
      4'd1: return 62;
      4'd2: return 16;
      4'd3: return 26;
      4'd4: return 102;
      4'd5: return 122;
      4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15: return 4 + 2*(int'(c) - 8);
      default: return 42;
    endcase
  endfunction

  function automatic logic [63:0] exp_frame(input logic [4:0] p, input logic [4:0] r,
                                            input bit w, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r, 2'b10, d};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic reg_write(input bit sel, input logic [15:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // one full transfer; inj adds ignored writes, including one on the final edge
  task automatic run_txn(input logic [4:0] p, input logic [4:0] r, input logic [3:0] c,
                         input bit w, input logic [15:0] d, input bit inj);
    logic [15:0] cmd;
    int per, cyc, hi0, v0;
    logic [63:0] ef, em;
    per = exp_period(c);
    cmd = {p, r, c, w, 1'b1};
    rd_val = d;
    if (w) reg_write(1'b1, d);
    base = falls; hi0 = hi_cnt; v0 = viol;
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = cmd;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R2 busy set after start", {63'd0, cmd_rdata[0]}, 64'd1);
    cyc = 0;
    while (cmd_rdata[0] && cyc < 10000) begin
      int n;
      n = cyc + 1;
      reg_wr = 1'b0;
      if (inj && n == 5)        begin reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = ~cmd | 16'h1; end
      if (inj && n == 9)        begin reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = ~d; end
      if (inj && n == 64*per)   begin reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 16'hFFFF; end
      cyc++;
      @(negedge clk);
    end
    reg_wr = 1'b0;
    chk(c <= 5 ? "R3 transfer length" : (c <= 7 ? "R5 reserved code length" : "R4 fast code length"),
        64'(cyc), 64'(64*per));
    chk("R3 mdc high half periods", 64'(hi_cnt - hi0), 64'(32*per));
    chk("R8 mdio changes only at mdc fall", 64'(viol - v0), 64'd0);
    ef = exp_frame(p, r, w, d);
    em = w ? {64{1'b1}} : {{46{1'b1}}, {18{1'b0}}};
    chk(w ? "R6 write frame bits" : "R7 read frame header", cap & em, ef & em);
    chk(w ? "R6 output enable" : "R7 output enable release", oecap, em);
    chk(w ? "R9 data kept on write" : "R7 read data loaded", 64'(data_rdata), 64'(d));
    chk("R10 command readback after done", 64'(cmd_rdata), 64'({cmd[15:1], 1'b0}));
    repeat (3) @(negedge clk);
    if (inj) chk("R9 no new transfer from late write", {63'd0, cmd_rdata[0]}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset command", 64'(cmd_rdata), 64'd0);
    chk("R1 reset data", 64'(data_rdata), 64'd0);
    chk("R1 reset line", {62'd0, mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11: command without busy bit is stored, nothing starts
    reg_write(1'b0, 16'hA5A8);
    repeat (20) @(negedge clk);
    chk("R11 stored without start", 64'(cmd_rdata), 64'hA5A8);
    chk("R11 mdc idle", 64'(idle_hi), 64'd0);

    // every range code, alternating direction
    for (int c = 0; c < 16; c++)
      run_txn(5'(c + 3), 5'(31 - c), 4'(c), c[0], 16'(16'h1234 * (c + 1) + 16'h0F0F), 1'b0);

    // ignored writes, one landing on the end edge
    run_txn(5'h1F, 5'h00, 4'd8, 1'b1, 16'hBEEF, 1'b1);
    run_txn(5'h00, 5'h1F, 4'd9, 1'b0, 16'h8001, 1'b1);
    run_txn(5'h11, 5'h0A, 4'd6, 1'b0, 16'h7FFE, 1'b1);

    // constrained random with fast codes
    void'($urandom(32'd2024));
    for (int i = 0; i < 24; i++) begin
      logic [3:0] c;
      c = 4'd8 + 4'($urandom_range(0, 7));
      run_txn(5'($urandom), 5'($urandom), c, 1'($urandom), 16'($urandom), 1'($urandom_range(0, 3) == 0));
    end

    chk("R8 mdc never high while idle", 64'(idle_hi), 64'd0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule